// File: doc/BRIEF.md
# Serial port flag and interrupt unit

This block keeps the status flags of an asynchronous serial port that moves 16-bit words and turns flag changes into interrupt requests. The host reaches it through a small register bus with four word registers: control, status, data and interrupt configuration. Bit-level framing and baud timing belong elsewhere. A periodic `tick_i` strobe from that logic moves the flag sequences forward.

A host write to the data register sends the word out on the transmit stream. The transmit flags then come back over two ticks. Received words enter an internal FIFO from the receive stream. The receive-full flag tells the host that the head word can be read. Every read of the data register starts a holdoff, and receive-full cannot be raised again until the holdoff has run down.

Each interrupt source is gated by its own enable bit. All requests made in one cycle merge into a single one-cycle pulse on `irq_o`. The vector and priority level that go with the pulse are taken from the configuration register.

Register map (`bus_addr_i`): 0 control, 1 status, 2 data, 3 interrupt configuration.
Control bits: 0 transmit enable, 1 receive enable, 2 transmit-empty interrupt enable, 3 transmit-complete interrupt enable, 4 receive interrupt enable.
Status bits: 8 transmit complete, 7 transmit empty, 6 receive full, 3 overrun.
Configuration: bits 15:8 vector, bits 2:0 level.

Top module: `serial_flag_unit`

## Requirements
- R1: After reset the status register reads 0x0180, `irq_o` is low, and the control register is zero.
- R2: A data-register write is accepted only when control bit 0 is 1. An accepted write puts the word on `tx_data_o` with `tx_valid_o` high in the next cycle and clears status bits 8 and 7. Otherwise the write has no effect.
- R3: The first tick after an accepted data write sets status bit 7 and requests an interrupt if control bit 2 is 1. The next tick sets status bit 8 and requests an interrupt if control bit 3 is 1.
- R4: A control write that changes bit 2 from 0 to 1 requests an interrupt at once. Writing bit 2 when it is already 1 does not.
- R5: On a tick, status bit 6 is set if the FIFO holds a word, control bit 1 is 1, the holdoff is zero and bit 6 is clear. An interrupt is requested then if control bit 4 is 1.
- R6: A data-register read with a non-empty FIFO returns the oldest word, removes it, clears status bit 6 and loads a 50-tick holdoff. Each later tick lowers the holdoff by one, so bit 6 can be set again at the 51st tick at the earliest.
- R7: A data-register read with an empty FIFO returns zero and changes neither the flags nor the holdoff.
- R8: While `irq_o` is high, `irq_vector_o` equals configuration bits 15:8 with bit 0 forced to 0, and `irq_level_o` equals configuration bits 2:0.
- R9: While control bit 1 is 0, received words stay in the FIFO. Once the bit is set they are delivered in order.
- R10: The FIFO holds 8 words. A word arriving while it is full and not being read is dropped and sets status bit 3. Writing 1 to status bit 3 clears it.
- R11: A word that arrives in the same cycle as a data read of a full FIFO is stored, and no overrun is flagged.
- R12: Interrupt requests made in one cycle appear as a single pulse on `irq_o` in the next cycle. The pulse lasts one cycle unless a new request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sequencing strobe for flags and holdoff |
| bus_req_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the cycle of the access |
| rx_valid_i | input | 1 | Received word strobe |
| rx_data_i | input | 16 | Received word |
| tx_valid_o | output | 1 | Transmit word strobe |
| tx_data_o | output | 16 | Transmit word |
| irq_o | output | 1 | Interrupt request pulse |
| irq_vector_o | output | 8 | Interrupt vector |
| irq_level_o | output | 3 | Interrupt level |

## Verification
Two pairs of functions can meet in one cycle. The first is a data read of a full FIFO together with an arriving word. The bench drives both in the same cycle and then drains the FIFO, expecting all nine words in order with no overrun flag. The second is a tick that raises transmit-empty and receive-full together while both interrupts are enabled. The bench expects exactly one `irq_o` pulse, and `irq_o` low again in the following cycle.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [1:0] {
    REG_CTL  = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_IRQ  = 2'd3
  } reg_sel_e;

  // control word, bit 0 is tx_en
  typedef struct packed {
    logic rx_ie;
    logic tc_ie;
    logic tx_ie;
    logic rx_en;
    logic tx_en;
  } ctl_t;

  localparam int unsigned CTL_W     = 5;
  localparam int unsigned CTL_TX_IE = 2;
  localparam int unsigned STAT_TC   = 8;
  localparam int unsigned STAT_TDRE = 7;
  localparam int unsigned STAT_RDRF = 6;
  localparam int unsigned STAT_OVR  = 3;
endpackage

// File: rtl/sfu_rx_fifo.sv
module sfu_rx_fifo #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              drop_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  // a pop in the same cycle frees the slot for the push
  assign do_push = push_i && (!full_o || do_pop);
  assign drop_o  = push_i && !do_push;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/sfu_tx_seq.sv
module sfu_tx_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic load_i,
  output logic tdre_o,
  output logic tc_o,
  output logic tdre_evt_o,
  output logic tc_evt_o
);
  typedef enum logic [1:0] {TX_IDLE, TX_STEP2, TX_STEP1} tx_st_e;
  tx_st_e st_q;

  assign tdre_evt_o = tick_i && !load_i && (st_q == TX_STEP1);
  assign tc_evt_o   = tick_i && !load_i && (st_q == TX_STEP2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      tdre_o <= 1'b1;
      tc_o   <= 1'b1;
    end else if (load_i) begin
      st_q   <= TX_STEP1;
      tdre_o <= 1'b0;
      tc_o   <= 1'b0;
    end else if (tdre_evt_o) begin
      st_q   <= TX_STEP2;
      tdre_o <= 1'b1;
    end else if (tc_evt_o) begin
      st_q   <= TX_IDLE;
      tc_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/sfu_rx_ctrl.sv
module sfu_rx_ctrl #(
  parameter int unsigned HOLDOFF = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_en_i,
  input  logic avail_i,
  input  logic read_i,
  output logic full_o,
  output logic set_evt_o
);
  localparam int unsigned HW = $clog2(HOLDOFF + 1);
  logic [HW-1:0] hold_q;

  assign set_evt_o = tick_i && !read_i && (hold_q == '0) &&
                     avail_i && rx_en_i && !full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_o <= 1'b0;
    end else if (read_i) begin
      hold_q <= HW'(HOLDOFF);
      full_o <= 1'b0;
    end else if (tick_i) begin
      if (hold_q != '0) hold_q <= hold_q - 1'b1;
      else if (set_evt_o) full_o <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_flag_unit.sv
module serial_flag_unit
  import sfu_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned HOLDOFF    = 50,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned LVL_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vector_o,
  output logic [LVL_W-1:0]  irq_level_o
);
  localparam int unsigned VEC_LSB = DATA_W - VEC_W;

  ctl_t              ctl_q;
  logic [VEC_W-1:1]  vec_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              ovr_q;
  logic              wr_ctl, wr_stat, wr_data, wr_irq, rd_data;
  logic              tx_load, fifo_pop, fifo_empty, fifo_full, fifo_drop;
  logic [DATA_W-1:0] fifo_head, stat_w;
  logic              tdre, tc, tdre_evt, tc_evt, rx_full, rx_evt;
  logic              tx_ie_rise, irq_req;
  logic              tx_en, tx_ie;

  assign wr_ctl  = bus_req_i && bus_we_i && (bus_addr_i == REG_CTL);
  assign wr_stat = bus_req_i && bus_we_i && (bus_addr_i == REG_STAT);
  assign wr_data = bus_req_i && bus_we_i && (bus_addr_i == REG_DATA);
  assign wr_irq  = bus_req_i && bus_we_i && (bus_addr_i == REG_IRQ);
  assign rd_data = bus_req_i && !bus_we_i && (bus_addr_i == REG_DATA);

  assign tx_en    = ctl_q.tx_en;
  assign tx_ie    = ctl_q.tx_ie;
  assign tx_load  = wr_data && tx_en;
  assign fifo_pop = rd_data && !fifo_empty;

  sfu_rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_valid_i),
    .data_i (rx_data_i),
    .pop_i  (fifo_pop),
    .head_o (fifo_head),
    .empty_o(fifo_empty),
    .full_o (fifo_full),
    .drop_o (fifo_drop)
  );

  sfu_tx_seq u_tx (
    .clk_i, .rst_ni,
    .tick_i    (tick_i),
    .load_i    (tx_load),
    .tdre_o    (tdre),
    .tc_o      (tc),
    .tdre_evt_o(tdre_evt),
    .tc_evt_o  (tc_evt)
  );

  sfu_rx_ctrl #(.HOLDOFF(HOLDOFF)) u_rx (
    .clk_i, .rst_ni,
    .tick_i   (tick_i),
    .rx_en_i  (ctl_q.rx_en),
    .avail_i  (!fifo_empty),
    .read_i   (fifo_pop),
    .full_o   (rx_full),
    .set_evt_o(rx_evt)
  );

  assign tx_ie_rise = wr_ctl && bus_wdata_i[CTL_TX_IE] && !tx_ie;
  assign irq_req    = tx_ie_rise
                   || (tdre_evt && tx_ie)
                   || (tc_evt   && ctl_q.tc_ie)
                   || (rx_evt   && ctl_q.rx_ie);

  always_comb begin
    stat_w            = '0;
    stat_w[STAT_TC]   = tc;
    stat_w[STAT_TDRE] = tdre;
    stat_w[STAT_RDRF] = rx_full;
    stat_w[STAT_OVR]  = ovr_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      REG_CTL:  bus_rdata_o[CTL_W-1:0] = ctl_q;
      REG_STAT: bus_rdata_o = stat_w;
      REG_DATA: bus_rdata_o = fifo_empty ? '0 : fifo_head;
      REG_IRQ: begin
        bus_rdata_o[DATA_W-1:VEC_LSB+1] = vec_q;
        bus_rdata_o[LVL_W-1:0]          = lvl_q;
      end
      default: bus_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= '0;
      vec_q      <= '0;
      lvl_q      <= '0;
      ovr_q      <= 1'b0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      irq_o      <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= bus_wdata_i[CTL_W-1:0];
      if (wr_irq) begin
        vec_q <= bus_wdata_i[DATA_W-1:VEC_LSB+1];
        lvl_q <= bus_wdata_i[LVL_W-1:0];
      end
      // a drop in the same cycle wins over the clear
      if (fifo_drop) ovr_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[STAT_OVR]) ovr_q <= 1'b0;
      tx_valid_o <= tx_load;
      if (tx_load) tx_data_o <= bus_wdata_i;
      irq_o <= irq_req;
    end
  end

  assign irq_vector_o = {vec_q, 1'b0};
  assign irq_level_o  = lvl_q;
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [1:0]        bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              rx_valid_i,
  input logic              tx_valid_o,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              irq_o,
  input logic              tx_en_i,
  input logic              tx_ie_i,
  input logic              fifo_full_i,
  input logic              fifo_empty_i,
  input logic              fifo_pop_i,
  input logic              ovr_i,
  input logic              rx_full_i
);
  p_tx_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == 2'd2 && !tx_en_i) |=> !tx_valid_o);

  p_tx_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_data_o == $past(bus_wdata_i));

  p_txie_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == 2'd0 && bus_wdata_i[2] && !tx_ie_i) |=> irq_o);

  p_rx_full_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_i) |-> $past(!fifo_empty_i));

  p_pop_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_i |=> !rx_full_i);

  p_empty_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i == 2'd2 && fifo_empty_i) |-> bus_rdata_o == '0);

  p_overrun_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && fifo_full_i && !fifo_pop_i) |=> ovr_i);

  p_push_at_full_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && fifo_full_i && fifo_pop_i) |=> (fifo_full_i && !$rose(ovr_i)));
endmodule

bind serial_flag_unit sfu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .rx_valid_i  (rx_valid_i),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .irq_o       (irq_o),
  .tx_en_i     (tx_en),
  .tx_ie_i     (tx_ie),
  .fifo_full_i (fifo_full),
  .fifo_empty_i(fifo_empty),
  .fifo_pop_i  (fifo_pop),
  .ovr_i       (ovr_q),
  .rx_full_i   (rx_full)
);

// File: tb/serial_flag_unit_test.sv
`timescale 1ns/1ps
module serial_flag_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_req_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = 2'd0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        rx_valid_i = 1'b0;
  logic [15:0] rx_data_i = '0;
  logic        tx_valid_o;
  logic [15:0] tx_data_o;
  logic        irq_o;
  logic [7:0]  irq_vector_o;
  logic [2:0]  irq_level_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  serial_flag_unit uut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_req_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = d;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    chk("R1 irq", {15'b0, irq_o}, 16'h0);
    rd(2'd1, v); chk("R1 status", v, 16'h0180);
    rd(2'd0, v); chk("R1 control", v, 16'h0000);
  endtask

  task automatic t_tx_blocked();
    logic [15:0] v;
    do_reset();
    wr(2'd2, 16'h1234);
    chk("R2 blocked valid", {15'b0, tx_valid_o}, 16'h0);
    rd(2'd1, v); chk("R2 blocked status", v, 16'h0180);
  endtask

  task automatic t_tx_seq();
    logic [15:0] v;
    do_reset();
    wr(2'd3, 16'h4B05);
    wr(2'd0, 16'h0009);
    chk("R4 no irq without bit2", {15'b0, irq_o}, 16'h0);
    wr(2'd2, 16'hA5C3);
    chk("R2 tx valid", {15'b0, tx_valid_o}, 16'h1);
    chk("R2 tx data", tx_data_o, 16'hA5C3);
    rd(2'd1, v); chk("R2 flags cleared", v, 16'h0000);
    tick();
    chk("R3 no tdre irq when disabled", {15'b0, irq_o}, 16'h0);
    rd(2'd1, v); chk("R3 step one", v, 16'h0080);
    tick();
    chk("R3 tc irq", {15'b0, irq_o}, 16'h1);
    chk("R8 vector", {8'b0, irq_vector_o}, 16'h004A);
    chk("R8 level", {13'b0, irq_level_o}, 16'h0005);
    rd(2'd1, v); chk("R3 step two", v, 16'h0180);
    tick();
    chk("R3 sequence over", {15'b0, irq_o}, 16'h0);
  endtask

  task automatic t_txie();
    do_reset();
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h0005);
    chk("R4 rise irq", {15'b0, irq_o}, 16'h1);
    wr(2'd0, 16'h0005);
    chk("R4 no irq when already set", {15'b0, irq_o}, 16'h0);
    wr(2'd2, 16'h0042);
    tick();
    chk("R3 tdre irq", {15'b0, irq_o}, 16'h1);
  endtask

  task automatic t_rx();
    logic [15:0] v;
    do_reset();
    push(16'h1111);
    push(16'h2222);
    repeat (3) tick();
    rd(2'd1, v); chk("R9 no full while disabled", v & 16'h0040, 16'h0);
    wr(2'd0, 16'h0012);
    tick();
    chk("R5 rx irq", {15'b0, irq_o}, 16'h1);
    rd(2'd1, v); chk("R5 full set", v & 16'h0040, 16'h0040);
    rd(2'd2, v); chk("R9 first word kept", v, 16'h1111);
    rd(2'd1, v); chk("R6 full cleared", v & 16'h0040, 16'h0);
    repeat (50) tick();
    rd(2'd1, v); chk("R6 held for 50 ticks", v & 16'h0040, 16'h0);
    tick();
    chk("R6 irq after holdoff", {15'b0, irq_o}, 16'h1);
    rd(2'd1, v); chk("R6 set on 51st tick", v & 16'h0040, 16'h0040);
    rd(2'd2, v); chk("R9 second word", v, 16'h2222);
  endtask

  task automatic t_empty_read();
    logic [15:0] v;
    do_reset();
    rd(2'd2, v); chk("R7 empty returns zero", v, 16'h0000);
    rd(2'd1, v); chk("R7 status unchanged", v, 16'h0180);
    wr(2'd0, 16'h0002);
    push(16'h0777);
    tick();
    rd(2'd1, v); chk("R7 no holdoff loaded", v & 16'h0040, 16'h0040);
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    do_reset();
    for (int i = 0; i < 9; i++) push(16'h0100 + 16'(i));
    rd(2'd1, v); chk("R10 overrun set", v & 16'h0008, 16'h0008);
    for (int i = 0; i < 8; i++) begin
      rd(2'd2, v); chk("R10 order", v, 16'h0100 + 16'(i));
    end
    rd(2'd2, v); chk("R10 ninth dropped", v, 16'h0000);
    wr(2'd1, 16'h0008);
    rd(2'd1, v); chk("R10 overrun cleared", v & 16'h0008, 16'h0);
  endtask

  task automatic t_same_cycle();
    logic [15:0] v;
    do_reset();
    for (int i = 0; i < 8; i++) push(16'h0200 + 16'(i));
    @(negedge clk_i);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = 2'd2;
    rx_valid_i = 1'b1; rx_data_i = 16'h02FF;
    #1 v = bus_rdata_o;
    @(negedge clk_i);
    bus_req_i = 1'b0; rx_valid_i = 1'b0;
    chk("R11 head word", v, 16'h0200);
    rd(2'd1, v); chk("R11 no overrun", v & 16'h0008, 16'h0);
    for (int i = 1; i < 8; i++) begin
      rd(2'd2, v); chk("R11 order", v, 16'h0200 + 16'(i));
    end
    rd(2'd2, v); chk("R11 pushed word kept", v, 16'h02FF);
  endtask

  task automatic t_merge();
    do_reset();
    wr(2'd0, 16'h0017);
    chk("R4 rise on enable", {15'b0, irq_o}, 16'h1);
    push(16'h0ABC);
    wr(2'd2, 16'h0055);
    @(negedge clk_i);
    chk("R12 idle before tick", {15'b0, irq_o}, 16'h0);
    tick();
    chk("R12 merged pulse", {15'b0, irq_o}, 16'h1);
    @(negedge clk_i);
    chk("R12 pulse ends", {15'b0, irq_o}, 16'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_tx_blocked();
    t_tx_seq();
    t_txie();
    t_rx();
    t_empty_read();
    t_overrun();
    t_same_cycle();
    t_merge();
    finish_run();
  end
endmodule